// File: doc/BRIEF.md
# External Bus Strobe Encoder

This block converts one internal bus request into the active-low strobes that an external memory or peripheral bus needs. A request carries an address, a direction (read or write) and a size (byte or word). The block latches the request, drives its strobes for a fixed number of clock cycles, then signals completion. Two static configuration inputs shape the output. One chooses between an 8-bit and a 16-bit external data bus. The other chooses how byte lanes are signalled on a 16-bit bus. In split-write style there is one read strobe and a separate write strobe for each byte lane. In lane-enable style there is one read strobe, one write strobe, and a high-lane enable that is combined with address bit 0.

Requests arrive on a valid/ready interface. `req_ready` is high only while the block is idle. A request is taken on a rising clock edge where both `req_valid` and `req_ready` are high. The requester must hold `req_valid` and the request fields steady until that edge. While an access is in progress, `req_ready` stays low, so a waiting request is held off until the access ends. Request fields that change after acceptance have no effect on the access already taken. The configuration inputs must only change while the block is idle.

A word request to an odd address on a 16-bit bus cannot be served. The block reports it on `err` and drives no strobes for it.

Top module: `bus_strobe_enc`

## Requirements
- R1: After reset, and whenever no access is in progress, `rd_n`, `wr_n`, `wrl_n`, `wrh_n` and `bhe_n` are all high, `done` and `err` are low, and `req_ready` is high. `a0` is 0 after reset.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the access ends. Request inputs that change after acceptance do not change the strobes or `a0` of the access in progress.
- R3: For a legal request, the strobes hold their access pattern for exactly ACTIVE_CYCLES clock cycles, starting in the cycle after acceptance. `done` is then high for the one cycle that follows, with all strobes high. `req_ready` returns high in the cycle after `done`.
- R4: With a 16-bit bus (`cfg_bus8`=0) and split-write style (`cfg_split_wr`=1), a read of any legal size drives only `rd_n` low. `wr_n`, `wrl_n`, `wrh_n` and `bhe_n` stay high.
- R5: With a 16-bit bus and split-write style, a write drives only its lane strobes low. `wrl_n` alone is low for a byte at an even address (`req_addr[0]`=0). `wrh_n` alone is low for a byte at an odd address. Both are low for a word. `rd_n`, `wr_n` and `bhe_n` stay high.
- R6: With a 16-bit bus and lane-enable style (`cfg_split_wr`=0), `rd_n` is low for a read and `wr_n` is low for a write. `bhe_n` is low for an odd byte or a word, and high for an even byte. `wrl_n` and `wrh_n` stay high.
- R7: On every accepted access, `a0` equals bit 0 of the accepted address, and it holds that value until the next acceptance.
- R8: With an 8-bit bus (`cfg_bus8`=1), a read drives only `rd_n` low and a write drives only `wr_n` low. `bhe_n`, `wrl_n` and `wrh_n` stay high. The style input, the size and the address bit 0 do not change which strobes are asserted.
- R9: A word request with `req_addr[0]`=1 on a 16-bit bus is accepted. In the next cycle `err` is high for one cycle, no strobe goes low, and `done` stays low. `req_ready` returns high in the cycle after that.
- R10: `rd_n` is never low in the same cycle as `wr_n`, `wrl_n` or `wrh_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bus8 | input | 1 | 1 selects an 8-bit external data bus, 0 a 16-bit bus (static) |
| cfg_split_wr | input | 1 | On a 16-bit bus: 1 selects split-write style, 0 lane-enable style (static) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_addr | input | ADDR_W | Request address (only bit 0 shapes the strobes) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_word | input | 1 | 1 for a word access, 0 for a byte access |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe in lane-enable style or on an 8-bit bus, active low |
| wrl_n | output | 1 | Low-lane (even byte) write strobe in split-write style, active low |
| wrh_n | output | 1 | High-lane (odd byte) write strobe in split-write style, active low |
| bhe_n | output | 1 | High-lane enable in lane-enable style, active low |
| a0 | output | 1 | Address bit 0 of the current or last access |
| done | output | 1 | One-cycle pulse after the active phase of a legal access |
| err | output | 1 | One-cycle pulse for a rejected odd-address word request |

## Verification
Some properties hold on every cycle, whatever the request, and the bound checker watches these continuously. These are: the read strobe never overlaps any write strobe; all strobes rest high while the block is ready or flagging an error; the lane and enable strobes stay high on an 8-bit bus; no strobe run lasts longer than the configured active phase; and `done` follows a complete run. The correct lane pattern for each combination of bus width, style, direction, size and address bit 0 can only be shown by the bench's scenarios. The same goes for the value on `a0`, and for the fact that inputs changed after acceptance are ignored. The bench sweeps all 32 such combinations and compares the pins against values it computes itself.

// File: rtl/bse_pkg.sv
package bse_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_DONE   = 2'd2,
    PH_FAULT  = 2'd3
  } phase_e;

  typedef struct packed {
    logic rd_n;
    logic wr_n;
    logic wrl_n;
    logic wrh_n;
    logic bhe_n;
  } strobe_t;

  typedef struct packed {
    logic write;
    logic word;
    logic a0;
    logic split;
    logic bus8;
  } access_t;

  localparam strobe_t STROBE_REST = '{rd_n: 1'b1, wr_n: 1'b1, wrl_n: 1'b1,
                                      wrh_n: 1'b1, bhe_n: 1'b1};

  // A word cannot start on an odd byte of a 16-bit bus.
  function automatic logic misaligned_word(input access_t acc);
    return acc.word && acc.a0 && !acc.bus8;
  endfunction

endpackage

// File: rtl/bse_lane_decode.sv
module bse_lane_decode
  import bse_pkg::*;
(
  input  access_t acc,
  output strobe_t pattern
);

  logic lane_lo;
  logic lane_hi;

  always_comb begin
    lane_lo = acc.word || !acc.a0;
    lane_hi = acc.word ||  acc.a0;
    pattern = STROBE_REST;
    pattern.rd_n = acc.write;
    if (acc.bus8) begin
      // Narrow bus: one byte per access, direction strobes only.
      pattern.wr_n = !acc.write;
    end else if (acc.split) begin
      pattern.wrl_n = !(acc.write && lane_lo);
      pattern.wrh_n = !(acc.write && lane_hi);
    end else begin
      pattern.wr_n  = !acc.write;
      pattern.bhe_n = !lane_hi;
    end
  end

endmodule

// File: rtl/bse_phase_ctrl.sv
module bse_phase_ctrl
  import bse_pkg::*;
#(
  parameter int ACTIVE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fault,
  output logic ready,
  output logic active,
  output logic done,
  output logic err
);

  phase_e phase_q;
  phase_e phase_d;
  logic   last_beat;

  generate
    if (ACTIVE_CYCLES <= 1) begin : g_single
      assign last_beat = 1'b1;
    end else begin : g_count
      localparam int CNT_W = $clog2(ACTIVE_CYCLES);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACTIVE_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (phase_q == PH_ACTIVE) begin
          cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
        end
      end

      assign last_beat = (cnt_q == CNT_LAST);
    end
  endgenerate

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (start) phase_d = fault ? PH_FAULT : PH_ACTIVE;
      PH_ACTIVE: if (last_beat) phase_d = PH_DONE;
      PH_DONE:   phase_d = PH_IDLE;
      PH_FAULT:  phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign ready  = (phase_q == PH_IDLE);
  assign active = (phase_q == PH_ACTIVE);
  assign done   = (phase_q == PH_DONE);
  assign err    = (phase_q == PH_FAULT);

endmodule

// File: rtl/bus_strobe_enc.sv
module bus_strobe_enc
  import bse_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int ACTIVE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bus8,
  input  logic              cfg_split_wr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_word,
  output logic              rd_n,
  output logic              wr_n,
  output logic              wrl_n,
  output logic              wrh_n,
  output logic              bhe_n,
  output logic              a0,
  output logic              done,
  output logic              err
);

  access_t acc_in;
  access_t acc_q;
  strobe_t pattern;
  strobe_t strobe_out;
  logic    take;
  logic    active;

  assign acc_in = '{write: req_write, word: req_word, a0: req_addr[0],
                    split: cfg_split_wr, bus8: cfg_bus8};
  assign take   = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= acc_in;
  end

  bse_phase_ctrl #(
    .ACTIVE_CYCLES(ACTIVE_CYCLES)
  ) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .start (take),
    .fault (misaligned_word(acc_in)),
    .ready (req_ready),
    .active(active),
    .done  (done),
    .err   (err)
  );

  bse_lane_decode u_decode (
    .acc    (acc_q),
    .pattern(pattern)
  );

  assign strobe_out = active ? pattern : STROBE_REST;
  assign rd_n  = strobe_out.rd_n;
  assign wr_n  = strobe_out.wr_n;
  assign wrl_n = strobe_out.wrl_n;
  assign wrh_n = strobe_out.wrh_n;
  assign bhe_n = strobe_out.bhe_n;
  assign a0    = acc_q.a0;

endmodule

// File: rtl/bse_strobe_checker.sv
module bse_strobe_checker #(
  parameter int ACTIVE_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_bus8,
  input logic req_ready,
  input logic rd_n,
  input logic wr_n,
  input logic wrl_n,
  input logic wrh_n,
  input logic bhe_n,
  input logic done,
  input logic err
);

  localparam int RUN_W = $clog2(ACTIVE_CYCLES + 2);

  logic             any_low;
  logic [RUN_W-1:0] run_q;

  assign any_low = !(rd_n && wr_n && wrl_n && wrh_n && bhe_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    run_q <= '0;
    else if (!any_low)                             run_q <= '0;
    else if (run_q != RUN_W'(ACTIVE_CYCLES + 1))   run_q <= run_q + 1'b1;
  end

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && (!wr_n || !wrl_n || !wrh_n))); // R10

  AST_IDLE_REST: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!any_low && !done && !err)); // R1

  AST_FAULT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!any_low && !done)); // R9

  AST_NARROW_LANES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bus8 |-> (bhe_n && wrl_n && wrh_n)); // R8

  AST_ACTIVE_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    any_low |-> (run_q < RUN_W'(ACTIVE_CYCLES))); // R3

  AST_DONE_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!any_low && run_q == RUN_W'(ACTIVE_CYCLES))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)); // R3

  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_low && run_q != '0) |-> $stable({rd_n, wr_n, wrl_n, wrh_n, bhe_n})); // R2

endmodule

bind bus_strobe_enc bse_strobe_checker #(
  .ACTIVE_CYCLES(ACTIVE_CYCLES)
) u_bse_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_bus8 (cfg_bus8),
  .req_ready(req_ready),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .wrl_n    (wrl_n),
  .wrh_n    (wrh_n),
  .bhe_n    (bhe_n),
  .done     (done),
  .err      (err)
);

// File: tb/bus_strobe_enc_bench.sv
module bus_strobe_enc_bench;

  localparam int ADDR_W = 20;
  localparam int NCYC   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_bus8 = 1'b0;
  logic              cfg_split_wr = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic              req_word = 1'b0;
  logic              rd_n, wr_n, wrl_n, wrh_n, bhe_n, a0, done, err;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_strobe_enc #(.ADDR_W(ADDR_W), .ACTIVE_CYCLES(NCYC)) u_bus_strobe_enc (
    .clk(clk), .rst_n(rst_n), .cfg_bus8(cfg_bus8), .cfg_split_wr(cfg_split_wr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .rd_n(rd_n), .wr_n(wr_n),
    .wrl_n(wrl_n), .wrh_n(wrh_n), .bhe_n(bhe_n), .a0(a0), .done(done), .err(err)
  );

  // Observed pins: {rd_n, wr_n, wrl_n, wrh_n, bhe_n, a0, done, err, req_ready}
  function automatic logic [8:0] pins();
    return {rd_n, wr_n, wrl_n, wrh_n, bhe_n, a0, done, err, req_ready};
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: pins rd,wr,wrl,wrh,bhe,a0,done,err,rdy actual %b expected %b",
               req, got, exp);
    end
  endtask

  task automatic run_case(input logic b8, input logic sp, input logic w,
                          input logic wd, input logic a, input int seed);
    logic       bad;
    logic [4:0] st;
    string      tag;
    bad = wd && a && !b8;
    // R4/R5/R6/R8: expected strobe pattern computed from the requirement text
    st = 5'b11111;
    st[4] = w;                                     // rd_n
    if (b8)      st[3] = !w;                       // R8
    else if (sp) begin                             // R4 R5
      st[2] = !(w && (wd || !a));
      st[1] = !(w && (wd || a));
    end else begin                                 // R6
      st[3] = !w;
      st[0] = !(wd || a);
    end
    tag = b8 ? "R8" : (sp ? (w ? "R5" : "R4") : "R6");

    @(negedge clk);
    cfg_bus8 = b8; cfg_split_wr = sp;
    req_addr = ADDR_W'(seed * 2) | ADDR_W'(a);
    req_write = w; req_word = wd; req_valid = 1'b1;
    check("R2 ready before accept", {pins()} & 9'b000000001, 9'b000000001);
    @(negedge clk);
    // R2: disturb the request inputs right after acceptance
    req_valid = 1'b0; req_write = !w; req_word = !wd; req_addr = ~req_addr;
    if (bad) begin
      check("R9 fault cycle", pins(), {5'b11111, a, 1'b0, 1'b1, 1'b0});
      @(negedge clk);
      check("R9 fault end", pins(), {5'b11111, a, 1'b0, 1'b0, 1'b1});
    end else begin
      for (int i = 0; i < NCYC; i++) begin
        check({tag, " R3 R7 active"}, pins(), {st, a, 1'b0, 1'b0, 1'b0});
        if (i == 0) begin
          req_valid = 1'b1;   // R2: held off while busy
        end
        @(negedge clk);
      end
      req_valid = 1'b0;
      check("R3 done pulse", pins(), {5'b11111, a, 1'b1, 1'b0, 1'b0});
      @(negedge clk);
      check("R1 R3 back to idle", pins(), {5'b11111, a, 1'b0, 1'b0, 1'b1});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", pins(), {5'b11111, 1'b0, 1'b0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", pins(), {5'b11111, 1'b0, 1'b0, 1'b0, 1'b1});
    for (int k = 0; k < 32; k++) begin
      run_case(k[4], k[3], k[2], k[1], k[0], k + 5);
    end
    // R2 back-to-back: second request waits through a busy access
    run_case(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 77);
    run_case(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 91);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule